// File: doc/BRIEF.md
# Recirculating Serial Pixel Store

This block keeps a one-bit-per-pixel image in one long shift ring rather than in an addressable array. The ring advances one place on every enabled pixel clock. The bit at the output tap drives the video stream and is also fed back into the far end of the ring. The picture therefore repeats in raster order without loss, and no separate refresh engine is needed. A column and row counter tracks which pixel sits at the tap, and it supplies the line and frame markers for a display timing stage.

A host changes the image through a one-entry write port that takes a column, a row and a bit. The port does not act at once. It holds the request until the addressed pixel comes round to the tap. On that enabled clock the new bit goes back into the ring in place of the recirculated one. A one-cycle completion pulse follows. The wait therefore depends on where the raster is when the request is taken, and it can be as long as one full rotation of the ring.

Top module: `rsfb_top`

## Requirements
- R1: After reset, every stored pixel is 0 and pixel 0 (column 0, row 0) is at the tap. This gives `vid_bit`=0, `line_start`=1, `frame_start`=1, `wr_ready`=1 and `wr_done`=0.
- R2: Each clock with `pix_en`=1 moves the tap to the next pixel in raster order, where pixel index = row*H_PIX + column, and wraps from the last pixel to 0. `line_start` is 1 exactly when the tap column is 0. `frame_start` is 1 exactly when the tap column and the tap row are both 0.
- R3: While `pix_en`=0 the ring and the tap position hold, so `vid_bit`, `line_start` and `frame_start` stay unchanged.
- R4: With no writes, `vid_bit` shows the stored bit of the pixel at the tap. The sequence repeats every H_PIX*V_LINES enabled clocks.
- R5: A pending write takes effect only on a clock where `pix_en`=1 and the tap index equals wr_y*H_PIX + wr_x. On that clock the written bit replaces the recirculated bit. `vid_bit` still shows the old value during that cycle, and the new value appears the next time the pixel reaches the tap.
- R6: One write can be pending at a time. A request is taken on a clock with `wr_valid`=1 and `wr_ready`=1. `wr_ready` is 0 from that clock until the write takes effect, and requests presented while `wr_ready`=0 are ignored.
- R7: `wr_done` is high for exactly one cycle, the cycle after the clock on which the write takes effect. `wr_ready` is 1 in that same cycle.
- R8: With `pix_en` held at 1, take a request at a clock after which the tap index is p, aimed at index t. The write takes effect ((t-p) mod N)+1 clocks after the request is taken, where N = H_PIX*V_LINES. The wait never exceeds N enabled clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Advance the ring by one pixel |
| wr_valid | input | 1 | Write request present |
| wr_x | input | clog2(H_PIX) | Column of the pixel to write |
| wr_y | input | clog2(V_LINES) | Row of the pixel to write |
| wr_val | input | 1 | Bit to store |
| wr_ready | output | 1 | No write pending; a request is taken |
| wr_done | output | 1 | One-cycle pulse after a write has been stored |
| vid_bit | output | 1 | Bit of the pixel at the tap |
| line_start | output | 1 | Tap is at column 0 |
| frame_start | output | 1 | Tap is at pixel 0 |

## Verification
The assertions check on every cycle the things that can be seen locally. They cover the frozen outputs while the enable is low, the single-cycle completion pulse and the ready state around it, the busy state after a request is taken, the frame marker implying the line marker, and a counter that bounds any wait to one rotation. Other properties need a model of the image and of the raster position: that the right pixel changes, that it changes on the correct clock, that refused requests leave no trace, and that latency follows the distance from the tap. Only the scoreboard scenarios can show these, under continuous, gated and stopped enables.

// File: rtl/rsfb_pkg.sv
package rsfb_pkg;
  typedef enum logic {
    WQ_IDLE = 1'b0,
    WQ_WAIT = 1'b1
  } wq_state_e;
endpackage

// File: rtl/rsfb_raster.sv
// Tracks the column and row of the pixel at the ring tap.
module rsfb_raster #(
  parameter  int H_PIX   = 32,
  parameter  int V_LINES = 8,
  localparam int XW      = $clog2(H_PIX),
  localparam int YW      = $clog2(V_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [XW-1:0] col,
  output logic [YW-1:0] row,
  output logic          line_start,
  output logic          frame_start
);
  localparam logic [XW-1:0] COL_LAST = XW'(H_PIX - 1);
  localparam logic [YW-1:0] ROW_LAST = YW'(V_LINES - 1);

  logic [XW-1:0] col_q, col_d;
  logic [YW-1:0] row_q, row_d;

  always_comb begin
    col_d = col_q;
    row_d = row_q;
    if (step) begin
      if (col_q == COL_LAST) begin
        col_d = '0;
        row_d = (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
      end else begin
        col_d = col_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else begin
      col_q <= col_d;
      row_q <= row_d;
    end
  end

  assign col         = col_q;
  assign row         = row_q;
  assign line_start  = (col_q == '0);
  assign frame_start = (col_q == '0) && (row_q == '0);
endmodule

// File: rtl/rsfb_ring.sv
// Circulating bit ring: stage 0 is the tap, the feed enters at the far end.
module rsfb_ring #(
  parameter int DEPTH = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic put_sel,
  input  logic put_bit,
  output logic tap_bit
);
  logic [DEPTH-1:0] ring_q, ring_d;
  logic             feed;

  assign feed = put_sel ? put_bit : ring_q[0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == DEPTH - 1) begin : g_far
      assign ring_d[i] = step ? feed : ring_q[i];
    end else begin : g_mid
      assign ring_d[i] = step ? ring_q[i+1] : ring_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ring_q <= '0;
    else        ring_q <= ring_d;
  end

  assign tap_bit = ring_q[0];
endmodule

// File: rtl/rsfb_wq.sv
// Single-entry write holder: waits until its pixel is at the tap.
module rsfb_wq
  import rsfb_pkg::*;
#(
  parameter int XW = 5,
  parameter int YW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          req_valid,
  input  logic [XW-1:0] req_x,
  input  logic [YW-1:0] req_y,
  input  logic          req_val,
  input  logic [XW-1:0] col,
  input  logic [YW-1:0] row,
  output logic          ready,
  output logic          done,
  output logic          hit,
  output logic          put_bit
);
  wq_state_e     st_q, st_d;
  logic [XW-1:0] x_q, x_d;
  logic [YW-1:0] y_q, y_d;
  logic          v_q, v_d;
  logic          done_q;

  assign hit = (st_q == WQ_WAIT) && step && (col == x_q) && (row == y_q);

  always_comb begin
    st_d = st_q;
    x_d  = x_q;
    y_d  = y_q;
    v_d  = v_q;
    if (st_q == WQ_IDLE) begin
      if (req_valid) begin
        st_d = WQ_WAIT;
        x_d  = req_x;
        y_d  = req_y;
        v_d  = req_val;
      end
    end else if (hit) begin
      st_d = WQ_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WQ_IDLE;
      x_q    <= '0;
      y_q    <= '0;
      v_q    <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      x_q    <= x_d;
      y_q    <= y_d;
      v_q    <= v_d;
      done_q <= hit;
    end
  end

  assign ready   = (st_q == WQ_IDLE);
  assign done    = done_q;
  assign put_bit = v_q;
endmodule

// File: rtl/rsfb_top.sv
module rsfb_top #(
  parameter  int H_PIX   = 32,
  parameter  int V_LINES = 8,
  localparam int XW      = $clog2(H_PIX),
  localparam int YW      = $clog2(V_LINES),
  localparam int NPIX    = H_PIX * V_LINES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic          wr_valid,
  input  logic [XW-1:0] wr_x,
  input  logic [YW-1:0] wr_y,
  input  logic          wr_val,
  output logic          wr_ready,
  output logic          wr_done,
  output logic          vid_bit,
  output logic          line_start,
  output logic          frame_start
);
  logic [XW-1:0] tap_col;
  logic [YW-1:0] tap_row;
  logic          put_sel;
  logic          put_bit;

  rsfb_raster #(.H_PIX(H_PIX), .V_LINES(V_LINES)) u_raster (
    .clk         (clk),
    .rst_n       (rst_n),
    .step        (pix_en),
    .col         (tap_col),
    .row         (tap_row),
    .line_start  (line_start),
    .frame_start (frame_start)
  );

  rsfb_wq #(.XW(XW), .YW(YW)) u_wq (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (pix_en),
    .req_valid (wr_valid),
    .req_x     (wr_x),
    .req_y     (wr_y),
    .req_val   (wr_val),
    .col       (tap_col),
    .row       (tap_row),
    .ready     (wr_ready),
    .done      (wr_done),
    .hit       (put_sel),
    .put_bit   (put_bit)
  );

  rsfb_ring #(.DEPTH(NPIX)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (pix_en),
    .put_sel (put_sel),
    .put_bit (put_bit),
    .tap_bit (vid_bit)
  );
endmodule

// File: rtl/rsfb_chk.sv
module rsfb_chk #(
  parameter int H_PIX   = 32,
  parameter int V_LINES = 8
) (
  input logic clk,
  input logic rst_n,
  input logic pix_en,
  input logic wr_valid,
  input logic wr_ready,
  input logic wr_done,
  input logic vid_bit,
  input logic line_start,
  input logic frame_start
);
  localparam int NPIX = H_PIX * V_LINES;
  localparam int CW   = $clog2(NPIX + 2) + 1;

  logic [CW-1:0] wait_q, wait_d;

  always_comb begin
    wait_d = wait_q;
    if (wr_ready)    wait_d = '0;
    else if (pix_en) wait_d = wait_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= '0;
    else        wait_q <= wait_d;
  end

  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(vid_bit) && $stable(line_start) && $stable(frame_start))); // R3
  AST_FRAME_IS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> line_start); // R2
  AST_LINE_MOVES_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && pix_en) |=> !line_start); // R2
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !wr_ready); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done); // R7
  AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> (wr_ready && !$past(wr_ready))); // R7
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q <= CW'(NPIX)); // R8
endmodule

bind rsfb_top rsfb_chk #(.H_PIX(H_PIX), .V_LINES(V_LINES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pix_en      (pix_en),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .wr_done     (wr_done),
  .vid_bit     (vid_bit),
  .line_start  (line_start),
  .frame_start (frame_start)
);

// File: tb/rsfb_top_test.sv
module rsfb_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 32;
  localparam int H  = 8;
  localparam int N  = W * H;
  localparam int XW = $clog2(W);
  localparam int YW = $clog2(H);

  logic clk = 1'b0;
  logic rst_n;
  logic pix_en;
  logic wr_valid;
  logic [XW-1:0] wr_x;
  logic [YW-1:0] wr_y;
  logic wr_val;
  logic wr_ready, wr_done, vid_bit, line_start, frame_start;

  rsfb_top #(.H_PIX(W), .V_LINES(H)) uut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .wr_valid(wr_valid),
    .wr_x(wr_x), .wr_y(wr_y), .wr_val(wr_val), .wr_ready(wr_ready),
    .wr_done(wr_done), .vid_bit(vid_bit), .line_start(line_start),
    .frame_start(frame_start)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int idx; bit v; } wr_item_t;
  wr_item_t exp_q[$];

  bit img [N];
  int b_col, b_row, last_idx;
  bit last_en, mon_on, prev_done;
  int en_mode, cyc;
  int nchk, nfail;

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  // reference raster position, advanced from the requirement R2
  always @(posedge clk) begin
    last_en  <= pix_en;
    last_idx <= b_row * W + b_col;
    if (rst_n && pix_en) begin
      if (b_col == W - 1) begin
        b_col <= 0;
        b_row <= (b_row == H - 1) ? 0 : b_row + 1;
      end else begin
        b_col <= b_col + 1;
      end
    end
  end

  // monitor: compares outputs against the image model and the queue
  always @(negedge clk) begin
    if (mon_on) begin
      chk(vid_bit == img[b_row*W + b_col], "R4 tap bit", int'(vid_bit), int'(img[b_row*W + b_col]));
      chk(line_start == (b_col == 0), "R2 line_start", int'(line_start), int'(b_col == 0));
      chk(frame_start == (b_col == 0 && b_row == 0), "R2 frame_start",
          int'(frame_start), int'(b_col == 0 && b_row == 0));
      if (wr_done) begin
        chk(!prev_done, "R7 done pulse width", 1, 0);
        chk(wr_ready, "R7 ready with done", int'(wr_ready), 1);
        if (exp_q.size() == 0) begin
          chk(0, "R6 done without request", 1, 0);
        end else begin
          wr_item_t it;
          it = exp_q.pop_front();
          chk(last_en && last_idx == it.idx, "R5 apply position", last_idx, it.idx);
          img[it.idx] = it.v;
        end
      end
      prev_done = wr_done;
    end
  end

  // enable driver
  initial begin
    pix_en = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      case (en_mode)
        0: pix_en = 1'b1;
        1: pix_en = (cyc % 3) != 0;
        default: pix_en = 1'b0;
      endcase
    end
  end

  task automatic do_write(int x, int y, bit v);
    wr_item_t it;
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_x = XW'(x); wr_y = YW'(y); wr_val = v;
    it.idx = y * W + x; it.v = v;
    exp_q.push_back(it);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // drive a request aimed k pixels past the tap position after acceptance
  task automatic start_rel(int k, bit v, output int tgt);
    wr_item_t it;
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    tgt = (b_row * W + b_col + k) % N;
    wr_valid = 1'b1; wr_x = XW'(tgt % W); wr_y = YW'(tgt / W); wr_val = v;
    it.idx = tgt; it.v = v;
    exp_q.push_back(it);
  endtask

  task automatic wait_idle;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    report();
    $finish;
  end

  initial begin
    int tgt, lat;
    bit sv, sl, sf;
    nchk = 0; nfail = 0; en_mode = 2; cyc = 0;
    mon_on = 0; prev_done = 0;
    b_col = 0; b_row = 0;
    for (int i = 0; i < N; i++) img[i] = 1'b0;
    wr_valid = 1'b0; wr_x = '0; wr_y = '0; wr_val = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(vid_bit == 1'b0, "R1 vid_bit", int'(vid_bit), 0);
    chk(line_start && frame_start, "R1 markers", int'(frame_start), 1);
    chk(wr_ready == 1'b1, "R1 wr_ready", int'(wr_ready), 1);
    chk(wr_done == 1'b0, "R1 wr_done", int'(wr_done), 0);
    mon_on = 1;

    // continuous enable: blank frame rotates, then scattered writes
    en_mode = 0;
    repeat (N + 10) @(negedge clk);
    do_write(3, 0, 1'b1);
    do_write(31, 7, 1'b1);
    do_write(0, 0, 1'b1);
    do_write(5, 2, 1'b1);
    wait_idle();
    repeat (2 * N) @(negedge clk);

    // R8 latency: pixel just ahead of the tap, then pixel just behind
    start_rel(1, 1'b1, tgt);
    lat = 0;
    do begin @(negedge clk); lat++; if (lat == 1) wr_valid = 1'b0; end while (!wr_done);
    chk(lat == 2, "R8 short wait", lat, 2);
    start_rel(N, 1'b1, tgt);
    lat = 0;
    do begin @(negedge clk); lat++; if (lat == 1) wr_valid = 1'b0; end while (!wr_done);
    chk(lat == N + 1, "R8 full rotation wait", lat, N + 1);

    // R6 requests while busy are ignored
    start_rel(120, 1'b1, tgt);
    @(negedge clk);
    wr_x = XW'(((tgt + 1) % N) % W); wr_y = YW'(((tgt + 1) % N) / W); wr_val = 1'b1;
    for (int i = 0; i < 6; i++) begin
      chk(!wr_ready, "R6 busy refuses", int'(wr_ready), 0);
      @(negedge clk);
    end
    wr_valid = 1'b0;
    wait_idle();
    repeat (N + 4) @(negedge clk);

    // R5 writing a zero over a set pixel
    do_write(3, 0, 1'b0);
    do_write(31, 7, 1'b0);
    wait_idle();
    repeat (N + 4) @(negedge clk);

    // gated enable with writes
    en_mode = 1;
    do_write(17, 4, 1'b1);
    do_write(2, 6, 1'b1);
    wait_idle();
    repeat (3 * N) @(negedge clk);

    // R3 enable held low: everything frozen, writes wait
    en_mode = 2;
    @(negedge clk); @(negedge clk);
    sv = vid_bit; sl = line_start; sf = frame_start;
    do_write(9, 1, 1'b1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(vid_bit == sv && line_start == sl && frame_start == sf, "R3 frozen", int'(vid_bit), int'(sv));
      chk(!wr_done && !wr_ready, "R3 write waits", int'(wr_done), 0);
    end
    en_mode = 0;
    wait_idle();
    repeat (N + 4) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all writes completed", exp_q.size(), 0);

    report();
    $finish;
  end
endmodule